// File: doc/BRIEF.md
# Cycle-Bit Descriptor Ring Consumer

This block walks a segmented ring of 16-byte descriptors held in a memory with a single read port. Ownership is settled by a cycle-bit handshake instead of head and tail pointers. The producer writes a descriptor and then sets that descriptor's cycle bit to the value the consumer currently expects. The consumer keeps its own copy of that expected value. Software programs a start address and an initial expected value through a load strobe, then rings the doorbell whenever it has queued new work.

After a doorbell the consumer reads the descriptor at its dequeue address as four 32-bit words; the fourth word is the control word. If the control word's cycle bit differs from the expected value, the descriptor still belongs to the producer, and the consumer goes back to idle. A link descriptor is never passed on. Instead it redirects the dequeue address to the start of another segment, and it can invert the expected cycle value, so a ring closes on itself with an odd number of inversions.

Every other descriptor is presented whole on a valid/ready stream. Chain bits group consecutive descriptors into transfers, and two flags on the stream mark the first and the last descriptor of each transfer. The dequeue address and the expected cycle value are visible at all times.

Top module: `trc_ring_consumer`

## Requirements
- R1: After reset, out_valid and mem_rd are low, deq_addr is 0 and cycle_state is 1.
- R2: A load pulse sets deq_addr to load_addr with bits 3:0 cleared and sets cycle_state to load_cycle, both visible in the following cycle. It abandons any fetch or pending output, returns the block to idle, and makes the next emitted descriptor the first of a transfer.
- R3: From idle, a doorbell pulse makes the block read the descriptor at deq_addr as four word reads at deq_addr, +4, +8 and +12, in that order. mem_rdata returns each word one cycle after its read. The fourth word is the control word.
- R4: A descriptor whose control bit 0 differs from cycle_state is not emitted and leaves deq_addr and cycle_state unchanged, and the block returns to idle without further reads. A doorbell that arrives while the block is busy is remembered, and it causes one refetch of that same descriptor.
- R5: A descriptor whose control bits 15:10 equal 6 is a link. It is never emitted. deq_addr becomes the address formed from word 1 (high) and word 0 (low), with bits 3:0 cleared. cycle_state is inverted when control bit 1 is set and kept when it is clear, and fetching continues without a doorbell.
- R6: An owned non-link descriptor is presented on out_trb (word 0 in bits 31:0, control word in bits 127:96) with out_valid high. It is held stable until out_ready is high. On acceptance, deq_addr advances by 16 and fetching continues.
- R7: out_last is the inverse of control bit 4 (the chain bit). out_first is high on the first descriptor after reset or load and on the descriptor after one emitted with out_last. A link between chained descriptors does not break the transfer, and the chain bit of a link is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Reload dequeue address and cycle state |
| load_addr | input | ADDR_W | Dequeue address to load |
| load_cycle | input | 1 | Cycle state to load |
| doorbell | input | 1 | New work has been queued |
| mem_rd | output | 1 | Word read request |
| mem_addr | output | ADDR_W | Byte address of the word being read |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |
| out_valid | output | 1 | Descriptor available |
| out_ready | input | 1 | Downstream accepts the descriptor |
| out_trb | output | 128 | Descriptor, word 0 in the low bits |
| out_first | output | 1 | First descriptor of a transfer |
| out_last | output | 1 | Last descriptor of a transfer |
| deq_addr | output | ADDR_W | Current dequeue address |
| cycle_state | output | 1 | Current expected cycle value |

## Verification
The assertions check the following on every cycle. A held descriptor stays stable while it waits for ready. Every emitted descriptor is owned and is never a link. The pointer moves by exactly one descriptor on acceptance, takes the loaded or linked value, and inverts only when the link asks for it. The four word reads step by four bytes. Only the bench's scenarios can show the rest: the transfer framing across a link, the refetch caused by a doorbell remembered during a fetch, the stall at an unowned descriptor and the resume on a later doorbell, and the fresh framing after a load that discards a waiting descriptor.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int WORD_W     = 32;
    localparam int TRB_WORDS  = 4;
    localparam int TRB_BYTES  = TRB_WORDS * (WORD_W / 8);
    localparam int TRB_BITS   = TRB_WORDS * WORD_W;
    localparam int ADDR_LSB   = $clog2(TRB_BYTES);
    localparam int CTL_WORD   = TRB_WORDS - 1;

    localparam int CYC_BIT    = 0;
    localparam int TOG_BIT    = 1;
    localparam int CHAIN_BIT  = 4;
    localparam int KIND_LSB   = 10;
    localparam int KIND_W     = 6;
    localparam logic [KIND_W-1:0] KIND_LINK = KIND_W'(6);

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [TRB_WORDS-1:0] trb_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_FETCH,
        ST_EMIT
    } cons_state_e;

    function automatic logic [KIND_W-1:0] trb_kind(trb_t t);
        return t[CTL_WORD][KIND_LSB +: KIND_W];
    endfunction

    function automatic logic trb_is_link(trb_t t);
        return trb_kind(t) == KIND_LINK;
    endfunction

    function automatic logic trb_owned(trb_t t, logic ccs);
        return t[CTL_WORD][CYC_BIT] == ccs;
    endfunction

    function automatic logic trb_chain(trb_t t);
        return t[CTL_WORD][CHAIN_BIT];
    endfunction

    function automatic logic trb_toggle(trb_t t);
        return t[CTL_WORD][TOG_BIT];
    endfunction

endpackage

// File: rtl/trc_fetch.sv
module trc_fetch
    import trc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  word_t             mem_rdata,
    output logic              done,
    output trb_t              trb
);
    localparam int CNT_W = $clog2(TRB_WORDS) + 1;
    localparam int IDX_W = $clog2(TRB_WORDS);

    logic              active_q;
    logic [CNT_W-1:0]  issue_q;
    logic [ADDR_W-1:0] base_q;
    logic              rsp_vld_q;
    logic [IDX_W-1:0]  rsp_idx_q;
    logic              done_q;
    word_t             words_q [TRB_WORDS];

    assign mem_rd   = active_q && (issue_q < CNT_W'(TRB_WORDS));
    assign mem_addr = base_q + ADDR_W'({issue_q, 2'b00});
    assign done     = done_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            active_q  <= 1'b0;
            issue_q   <= '0;
            base_q    <= '0;
            rsp_vld_q <= 1'b0;
            rsp_idx_q <= '0;
            done_q    <= 1'b0;
        end else begin
            rsp_vld_q <= mem_rd;
            rsp_idx_q <= issue_q[IDX_W-1:0];
            done_q    <= rsp_vld_q && (rsp_idx_q == IDX_W'(TRB_WORDS - 1));
            if (start) begin
                active_q <= 1'b1;
                issue_q  <= '0;
                base_q   <= base_addr;
            end else begin
                if (mem_rd) begin
                    issue_q <= issue_q + 1'b1;
                end
                if (rsp_vld_q && (rsp_idx_q == IDX_W'(TRB_WORDS - 1))) begin
                    active_q <= 1'b0;
                end
            end
        end
    end

    for (genvar g = 0; g < TRB_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words_q[g] <= '0;
            end else if (rsp_vld_q && (rsp_idx_q == IDX_W'(g))) begin
                words_q[g] <= mem_rdata;
            end
        end
        assign trb[g] = words_q[g];
    end

    AST_RD_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(4))) // R3
        else $error("consecutive word reads do not step by four");

endmodule

// File: rtl/trc_ring_ptr.sv
module trc_ring_ptr
    import trc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_cycle,
    input  logic              advance,
    input  logic              take_link,
    input  logic [ADDR_W-1:0] link_addr,
    input  logic              link_toggle,
    output logic [ADDR_W-1:0] deq_addr,
    output logic              cycle_state
);
    logic [ADDR_W-1:0] deq_q;
    logic              ccs_q;

    function automatic logic [ADDR_W-1:0] align_trb(logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:ADDR_LSB], ADDR_LSB'(0)};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            deq_q <= '0;
            ccs_q <= 1'b1;
        end else if (load) begin
            deq_q <= align_trb(load_addr);
            ccs_q <= load_cycle;
        end else if (take_link) begin
            deq_q <= align_trb(link_addr);
            if (link_toggle) begin
                ccs_q <= ~ccs_q;
            end
        end else if (advance) begin
            deq_q <= deq_q + ADDR_W'(TRB_BYTES);
        end
    end

    assign deq_addr    = deq_q;
    assign cycle_state = ccs_q;

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load |=> (deq_addr[ADDR_W-1:ADDR_LSB] == $past(load_addr[ADDR_W-1:ADDR_LSB])
                  && deq_addr[ADDR_LSB-1:0] == '0
                  && cycle_state == $past(load_cycle))) // R2
        else $error("load not taken");

    AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && !take_link) |=>
            (deq_addr == $past(deq_addr) + ADDR_W'(TRB_BYTES) && $stable(cycle_state))) // R6
        else $error("advance did not move by one descriptor");

    AST_LINK_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (take_link && !load) |=> (cycle_state == ($past(cycle_state) ^ $past(link_toggle)))) // R5
        else $error("link cycle update wrong");

endmodule

// File: rtl/trc_ring_consumer.sv
module trc_ring_consumer
    import trc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [ADDR_W-1:0]   load_addr,
    input  logic                load_cycle,
    input  logic                doorbell,
    output logic                mem_rd,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [TRB_BITS-1:0] out_trb,
    output logic                out_first,
    output logic                out_last,
    output logic [ADDR_W-1:0]   deq_addr,
    output logic                cycle_state
);
    cons_state_e state_q, state_d;
    logic        pend_q;
    logic        in_td_q;

    logic        fetch_start;
    logic        fetch_done;
    trb_t        trb;
    logic        advance;
    logic        take_link;
    logic [ADDR_W-1:0] link_addr;

    trc_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .abort     (load),
        .start     (fetch_start),
        .base_addr (deq_addr),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .done      (fetch_done),
        .trb       (trb)
    );

    assign link_addr = ADDR_W'({trb[1], trb[0]});

    trc_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .load_addr   (load_addr),
        .load_cycle  (load_cycle),
        .advance     (advance),
        .take_link   (take_link),
        .link_addr   (link_addr),
        .link_toggle (trb_toggle(trb)),
        .deq_addr    (deq_addr),
        .cycle_state (cycle_state)
    );

    always_comb begin
        state_d     = state_q;
        fetch_start = 1'b0;
        advance     = 1'b0;
        take_link   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (doorbell) begin
                    state_d = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                fetch_start = 1'b1;
                state_d     = ST_FETCH;
            end
            ST_FETCH: begin
                if (fetch_done) begin
                    if (!trb_owned(trb, cycle_state)) begin
                        state_d = (pend_q || doorbell) ? ST_LAUNCH : ST_IDLE;
                    end else if (trb_is_link(trb)) begin
                        take_link = 1'b1;
                        state_d   = ST_LAUNCH;
                    end else begin
                        state_d = ST_EMIT;
                    end
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    advance = 1'b1;
                    state_d = ST_LAUNCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            in_td_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LAUNCH) begin
                pend_q <= 1'b0;
            end else if (doorbell && state_q != ST_IDLE) begin
                pend_q <= 1'b1;
            end
            if (advance) begin
                in_td_q <= trb_chain(trb);
            end
        end
    end

    assign out_valid = (state_q == ST_EMIT);
    assign out_trb   = trb;
    assign out_first = !in_td_q;
    assign out_last  = !trb_chain(trb);

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !load) |=> (out_valid && $stable(out_trb))) // R6
        else $error("descriptor changed while waiting for ready");

    AST_EMIT_OWNED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_trb[WORD_W*CTL_WORD + CYC_BIT] == cycle_state)) // R4
        else $error("emitted descriptor not owned");

    AST_NO_LINK_OUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_trb[WORD_W*CTL_WORD + KIND_LSB +: KIND_W] != KIND_LINK)) // R5
        else $error("link descriptor emitted");

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !mem_rd)) // R1
        else $error("activity right after reset");

endmodule

// File: tb/trc_ring_consumer_tb.sv
module trc_ring_consumer_tb;
    import trc_pkg::*;
    localparam int AW = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst, load, load_cycle, doorbell, out_ready;
    logic [AW-1:0] load_addr;
    logic          mem_rd, out_valid, out_first, out_last, cycle_state;
    logic [AW-1:0] mem_addr, deq_addr;
    logic [31:0]   mem_rdata;
    logic [127:0]  out_trb;

    trc_ring_consumer #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .load(load), .load_addr(load_addr),
        .load_cycle(load_cycle), .doorbell(doorbell), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .out_ready(out_ready), .out_trb(out_trb), .out_first(out_first),
        .out_last(out_last), .deq_addr(deq_addr), .cycle_state(cycle_state)
    );

    logic [31:0] mem [0:63];
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:2]];

    int          rd_n;
    logic [AW-1:0] rd_log [0:63];
    always @(negedge clk) if (mem_rd) begin
        if (rd_n < 64) rd_log[rd_n] = mem_addr;
        rd_n++;
    end

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // control word: bits 15:10 kind (1 normal, 6 link), bit 4 chain, bit 1 toggle, bit 0 cycle
    task automatic put_norm(int a, logic [31:0] tag, bit chain, bit cyc);
        mem[a/4]   = tag;
        mem[a/4+1] = 32'h0;
        mem[a/4+2] = 32'h0;
        mem[a/4+3] = (32'd1 << 10) | (32'(chain) << 4) | 32'(cyc);
    endtask

    task automatic put_link(int a, logic [31:0] tgt, bit tog, bit chain, bit cyc);
        mem[a/4]   = tgt;
        mem[a/4+1] = 32'h0;
        mem[a/4+2] = 32'h0;
        mem[a/4+3] = (32'd6 << 10) | (32'(chain) << 4) | (32'(tog) << 1) | 32'(cyc);
    endtask

    task automatic put_stop(int a);
        mem[a/4+3] = 32'h0000_0401;
    endtask

    task automatic ring();
        doorbell = 1'b1;
        @(negedge clk);
        doorbell = 1'b0;
    endtask

    task automatic do_load(logic [AW-1:0] a, bit c);
        load_addr  = a;
        load_cycle = c;
        load       = 1'b1;
        @(negedge clk);
        load       = 1'b0;
    endtask

    task automatic expect_trb(logic [31:0] tag, bit first, bit last,
                              logic [AW-1:0] next_deq, string req);
        bit seen = 0;
        for (int i = 0; i < 60 && !seen; i++) begin
            @(negedge clk);
            if (out_valid) seen = 1;
        end
        chk(seen, {req, " descriptor presented"}, 64'(seen), 64'd1);
        if (!seen) return;
        chk(out_trb[31:0] == tag, {req, " tag"}, 64'(out_trb[31:0]), 64'(tag));
        chk(out_first == first, {req, " first (R7)"}, 64'(out_first), 64'(first));
        chk(out_last == last, {req, " last (R7)"}, 64'(out_last), 64'(last));
        repeat (3) @(negedge clk);
        chk(out_valid && out_trb[31:0] == tag, "R6 hold without ready",
            64'(out_trb[31:0]), 64'(tag));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(deq_addr == next_deq, "R6 advance after accept", 64'(deq_addr), 64'(next_deq));
    endtask

    task automatic expect_quiet(int n, string req);
        bit bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (out_valid) bad = 1;
        end
        chk(!bad, req, 64'(bad), 64'd0);
    endtask

    task automatic t_reset();
        chk(!out_valid, "R1 out_valid", 64'(out_valid), 64'd0);
        chk(!mem_rd, "R1 mem_rd", 64'(mem_rd), 64'd0);
        chk(deq_addr == 0, "R1 deq_addr", 64'(deq_addr), 64'd0);
        chk(cycle_state == 1'b1, "R1 cycle_state", 64'(cycle_state), 64'd1);
    endtask

    task automatic t_empty_ring();
        rd_n = 0;
        ring();
        @(negedge clk);
        ring();
        expect_quiet(30, "R4 nothing emitted from unowned ring");
        chk(rd_n == 8, "R4 one refetch for doorbell during fetch", 64'(rd_n), 64'd8);
        for (int i = 0; i < 4; i++)
            chk(rd_log[i] == AW'(4 * i), "R3 word read order", 64'(rd_log[i]), 64'(4 * i));
        chk(rd_log[4] == 0, "R4 refetch same descriptor", 64'(rd_log[4]), 64'd0);
        repeat (20) @(negedge clk);
        chk(rd_n == 8, "R4 idle after stall, no reads", 64'(rd_n), 64'd8);
        chk(deq_addr == 0 && cycle_state == 1'b1, "R4 pointer unchanged",
            64'({deq_addr, cycle_state}), 64'({32'd0, 1'b1}));
    endtask

    task automatic t_walk_links();
        put_norm(32'h00, 32'hA1, 1, 1);
        put_norm(32'h10, 32'hA2, 0, 1);
        put_link(32'h20, 32'h80, 0, 1, 1);
        put_norm(32'h80, 32'hB1, 1, 1);
        put_link(32'h90, 32'h47, 1, 0, 1);
        put_norm(32'h40, 32'hB2, 0, 0);
        put_stop(32'h50);
        put_stop(32'h60);
        put_stop(32'h70);
        put_stop(32'hB0);
        ring();
        expect_trb(32'hA1, 1, 0, 32'h10, "R6 A1");
        expect_trb(32'hA2, 0, 1, 32'h20, "R7 A2");
        expect_trb(32'hB1, 1, 0, 32'h90, "R5 B1 after plain link");
        expect_trb(32'hB2, 0, 1, 32'h50, "R7 B2 across toggling link");
        expect_quiet(20, "R4 stop at unowned descriptor");
        chk(deq_addr == 32'h50, "R5 link target reached", 64'(deq_addr), 64'h50);
        chk(cycle_state == 1'b0, "R5 toggle inverted cycle", 64'(cycle_state), 64'd0);
    endtask

    task automatic t_resume();
        put_norm(32'h50, 32'hC1, 0, 0);
        ring();
        expect_trb(32'hC1, 1, 1, 32'h60, "R3 resume on doorbell");
    endtask

    task automatic t_load_framing();
        put_norm(32'h60, 32'hD1, 1, 0);
        ring();
        expect_trb(32'hD1, 1, 0, 32'h70, "R7 open transfer");
        expect_quiet(10, "R4 stall mid transfer");
        do_load(32'hA7, 0);
        chk(deq_addr == 32'hA0, "R2 load aligns address", 64'(deq_addr), 64'hA0);
        chk(cycle_state == 1'b0, "R2 load cycle", 64'(cycle_state), 64'd0);
        put_norm(32'hA0, 32'hE1, 0, 0);
        ring();
        expect_trb(32'hE1, 1, 1, 32'hB0, "R2 load restarts framing");
    endtask

    task automatic t_load_discard();
        do_load(32'h05, 1);
        chk(deq_addr == 0 && cycle_state == 1'b1, "R2 load back to start",
            64'({deq_addr, cycle_state}), 64'({32'd0, 1'b1}));
        ring();
        expect_trb(32'hA1, 1, 0, 32'h10, "R2 A1 again");
        for (int i = 0; i < 60 && !out_valid; i++) @(negedge clk);
        chk(out_valid && out_trb[31:0] == 32'hA2, "R6 A2 waiting",
            64'(out_trb[31:0]), 64'hA2);
        do_load(32'h40, 0);
        chk(!out_valid, "R2 load drops waiting descriptor", 64'(out_valid), 64'd0);
        chk(deq_addr == 32'h40, "R2 load address", 64'(deq_addr), 64'h40);
        ring();
        expect_trb(32'hB2, 1, 1, 32'h50, "R2 first after discard");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        rst = 1'b1; load = 1'b0; load_addr = '0; load_cycle = 1'b0;
        doorbell = 1'b0; out_ready = 1'b0; rd_n = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_empty_ring();
        t_walk_links();
        t_resume();
        t_load_framing();
        t_load_discard();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule